// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block folds the level-sensitive interrupt pins of several devices onto a small set of shared interrupt outputs. Each device has four pins. A fixed rotation routes each pin to a shared line, and the rotation depends on the device number. For each line the block keeps a count of how many routed pins are currently high. The line output is driven while that count is nonzero. A plain OR gate would give the same output level. The count is kept so that the line state can be maintained incrementally: a counter moves only when a stored pin level actually changes, and it never has to recompute the OR from scratch.

Pin levels arrive as per-pin write strobes with a level. The block holds the last applied level of every pin. Several pins may change in one cycle, and the counter of each line absorbs all of those changes in a single update.

A snapshot port reads any device's four stored levels as a 4-bit vector. A restore stream writes a 4-bit vector back into one device. Each restored bit goes through the same edge logic as a normal pin write, so the counters stay consistent. The restore stream is valid/ready. The sender must hold `rst_vld`, `rst_dev` and `rst_vec` stable until a cycle in which `rst_rdy` is high. Ready drops only in a cycle in which a direct pin write targets the same device. A restore beat that is offered while ready is low has no effect.

Top module: `irq_line_agg`

## Requirements
- R1: A synchronous active-high `rst` clears every stored pin level, every line output and `err_flag`.
- R2: A pin write whose level equals the stored level of that pin leaves `line_out` and every stored level unchanged.
- R3: Pin `p` of device `d` (write strobe and level at bit `4*d+p` of `pin_we`/`pin_lvl`) is routed to line `(p + d) mod NUM_LINES`.
- R4: After each rising clock edge, `line_out[l]` is high exactly when at least one pin routed to line `l` has a stored high level. The outputs reflect the writes taken at that edge.
- R5: A line shared by several high pins stays high until the last of them falls. Any number of rises and falls on one line in the same cycle are applied together.
- R6: `snap_vec` bit `i` is the stored level of pin `i` of device `snap_dev`. It is combinational from the stored state.
- R7: An accepted restore beat (`rst_vld` and `rst_rdy` both high) sets the four stored levels of device `rst_dev` to `rst_vec`, with bit `i` going to pin `i`. Lines update as for normal writes. Pin writes to other devices in the same cycle still apply.
- R8: `rst_rdy` is low exactly when any `pin_we` bit of device `rst_dev` is set in that cycle. A restore beat offered while ready is low has no effect.
- R9: `err_flag` is a sticky flag set when a line count would drop below zero. Port stimulus alone never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_we | input | NUM_DEV*4 | Per-pin write strobe, bit 4*d+p |
| pin_lvl | input | NUM_DEV*4 | Per-pin level applied when strobed |
| snap_dev | input | DEVW | Device whose stored levels appear on snap_vec |
| snap_vec | output | 4 | Stored levels of device snap_dev, pin i at bit i |
| rst_vld | input | 1 | Restore beat valid |
| rst_rdy | output | 1 | Restore beat ready |
| rst_dev | input | DEVW | Device targeted by the restore beat |
| rst_vec | input | 4 | Levels restored, bit i to pin i |
| line_out | output | NUM_LINES | Shared interrupt lines |
| err_flag | output | 1 | Sticky count-underflow flag |

## Verification
The bench builds the block with four devices and four lines. With that configuration all sixteen pins fit in one 16-bit pattern, and every line collects exactly one pin from each device. A reference of stored levels in the bench yields the expected line vector as an arithmetic OR over the rotation. This makes it possible to walk every pin through the rotation individually and to sweep thousands of full-width and partial-strobe patterns. It also lets the bench exercise all 64 device/vector restore combinations, each mixed with conflicting direct writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int PINS_PER_DEV = 4;

  // Rotation routing: pin index plus device number, wrapped to the line count.
  function automatic int unsigned route_line(input int unsigned dev,
                                             input int unsigned pin,
                                             input int unsigned nlines);
    return (dev + pin) % nlines;
  endfunction
endpackage

// File: rtl/irq_pin_bank.sv
module irq_pin_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEVW    = 2,
  localparam int NPIN   = NUM_DEV * PINS_PER_DEV
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPIN-1:0]         pin_we,
  input  logic [NPIN-1:0]         pin_lvl,
  input  logic                    rest_fire,
  input  logic [DEVW-1:0]         rest_dev,
  input  logic [PINS_PER_DEV-1:0] rest_vec,
  output logic [NPIN-1:0]         lvl_q,
  output logic [NPIN-1:0]         rise,
  output logic [NPIN-1:0]         fall
);
  logic [NPIN-1:0] lvl_d;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [DEVW-1:0] DID = DEVW'(d);
    logic hit;
    assign hit = rest_fire && (rest_dev == DID);
    for (genvar p = 0; p < PINS_PER_DEV; p++) begin : g_pin
      localparam int IDX = d * PINS_PER_DEV + p;
      always_comb begin
        if (hit)              lvl_d[IDX] = rest_vec[p];
        else if (pin_we[IDX]) lvl_d[IDX] = pin_lvl[IDX];
        else                  lvl_d[IDX] = lvl_q[IDX];
      end
    end
  end

  assign rise = lvl_d & ~lvl_q;
  assign fall = ~lvl_d & lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_d;
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  parameter int LINE      = 0,
  localparam int NPIN     = NUM_DEV * PINS_PER_DEV,
  localparam int CW       = $clog2(NPIN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] rise,
  input  logic [NPIN-1:0] fall,
  output logic [CW-1:0]   cnt_q,
  output logic            active,
  output logic            err_q
);
  logic [CW-1:0] n_up, n_dn;
  logic [CW:0]   sum, diff;
  logic          under;

  always_comb begin
    n_up = '0;
    n_dn = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS_PER_DEV; p++) begin
        if (route_line(d, p, NUM_LINES) == LINE) begin
          n_up = n_up + CW'(rise[d * PINS_PER_DEV + p]);
          n_dn = n_dn + CW'(fall[d * PINS_PER_DEV + p]);
        end
      end
    end
    sum   = {1'b0, cnt_q} + {1'b0, n_up};
    under = {1'b0, n_dn} > sum;
    diff  = under ? '0 : (sum - {1'b0, n_dn});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= diff[CW-1:0];
      if (under) err_q <= 1'b1;
    end
  end

  assign active = |cnt_q;
endmodule

// File: rtl/irq_snap_port.sv
module irq_snap_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEVW    = 2,
  localparam int NPIN   = NUM_DEV * PINS_PER_DEV
) (
  input  logic [NPIN-1:0]         lvl_q,
  input  logic [NPIN-1:0]         pin_we,
  input  logic [DEVW-1:0]         snap_dev,
  output logic [PINS_PER_DEV-1:0] snap_vec,
  input  logic                    rest_vld,
  input  logic [DEVW-1:0]         rest_dev,
  output logic                    rest_rdy,
  output logic                    rest_fire
);
  always_comb begin
    snap_vec = '0;
    rest_rdy = 1'b1;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (snap_dev == DEVW'(d))
        snap_vec = lvl_q[d * PINS_PER_DEV +: PINS_PER_DEV];
      if (rest_dev == DEVW'(d) && |pin_we[d * PINS_PER_DEV +: PINS_PER_DEV])
        rest_rdy = 1'b0;
    end
  end

  assign rest_fire = rest_vld && rest_rdy;
endmodule

// File: rtl/irq_line_agg.sv
module irq_line_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  localparam int NPIN     = NUM_DEV * PINS_PER_DEV,
  localparam int DEVW     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int CW       = $clog2(NPIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPIN-1:0]         pin_we,
  input  logic [NPIN-1:0]         pin_lvl,
  input  logic [DEVW-1:0]         snap_dev,
  output logic [PINS_PER_DEV-1:0] snap_vec,
  input  logic                    rst_vld,
  output logic                    rst_rdy,
  input  logic [DEVW-1:0]         rst_dev,
  input  logic [PINS_PER_DEV-1:0] rst_vec,
  output logic [NUM_LINES-1:0]    line_out,
  output logic                    err_flag
);
  logic [NPIN-1:0]      lvl_q, rise, fall;
  logic                 rest_fire;
  logic [NUM_LINES-1:0] line_err;

  irq_snap_port #(.NUM_DEV(NUM_DEV), .DEVW(DEVW)) u_port (
    .lvl_q     (lvl_q),
    .pin_we    (pin_we),
    .snap_dev  (snap_dev),
    .snap_vec  (snap_vec),
    .rest_vld  (rst_vld),
    .rest_dev  (rst_dev),
    .rest_rdy  (rst_rdy),
    .rest_fire (rest_fire)
  );

  irq_pin_bank #(.NUM_DEV(NUM_DEV), .DEVW(DEVW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .pin_we    (pin_we),
    .pin_lvl   (pin_lvl),
    .rest_fire (rest_fire),
    .rest_dev  (rst_dev),
    .rest_vec  (rst_vec),
    .lvl_q     (lvl_q),
    .rise      (rise),
    .fall      (fall)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CW-1:0] cnt;
    irq_line_counter #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES), .LINE(l)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .rise   (rise),
      .fall   (fall),
      .cnt_q  (cnt),
      .active (line_out[l]),
      .err_q  (line_err[l])
    );
  end

  assign err_flag = |line_err;
endmodule

// File: rtl/irq_line_agg_chk.sv
module irq_line_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  localparam int NPIN     = NUM_DEV * PINS_PER_DEV,
  localparam int DEVW     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NPIN-1:0]      pin_we,
  input logic                 rst_vld,
  input logic                 rst_rdy,
  input logic [DEVW-1:0]      rst_dev,
  input logic [NUM_LINES-1:0] line_out,
  input logic                 err_flag,
  input logic [NPIN-1:0]      lvl_q
);
  logic [NUM_LINES-1:0] ref_or;
  logic                 coll;

  always_comb begin
    ref_or = '0;
    coll   = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS_PER_DEV; p++)
        if (lvl_q[d * PINS_PER_DEV + p]) ref_or[route_line(d, p, NUM_LINES)] = 1'b1;
      if (rst_dev == DEVW'(d) && |pin_we[d * PINS_PER_DEV +: PINS_PER_DEV]) coll = 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (line_out == '0 && !err_flag && lvl_q == '0)); // R1

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pin_we == '0 && !(rst_vld && rst_rdy)) |=> ($stable(line_out) && $stable(lvl_q))); // R2

  AST_LINE_IS_OR: assert property (@(posedge clk) disable iff (rst) line_out == ref_or); // R4

  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst) rst_rdy == !coll); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) !err_flag); // R9
endmodule

bind irq_line_agg irq_line_agg_chk #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_we   (pin_we),
  .rst_vld  (rst_vld),
  .rst_rdy  (rst_rdy),
  .rst_dev  (rst_dev),
  .line_out (line_out),
  .err_flag (err_flag),
  .lvl_q    (lvl_q)
);

// File: tb/sim_irq_line_agg.sv
`timescale 1ns/1ps
module sim_irq_line_agg;
  localparam int ND = 4;
  localparam int NL = 4;
  localparam int NP = ND * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_we = '0, pin_lvl = '0;
  logic [1:0]    snap_dev = '0;
  logic [3:0]    snap_vec;
  logic          rst_vld = 1'b0;
  logic          rst_rdy;
  logic [1:0]    rst_dev = '0;
  logic [3:0]    rst_vec = '0;
  logic [NL-1:0] line_out;
  logic          err_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NP-1:0] ref_lvl = '0;

  always #2.5 clk = ~clk;

  irq_line_agg #(.NUM_DEV(ND), .NUM_LINES(NL)) u0 (
    .clk(clk), .rst(rst), .pin_we(pin_we), .pin_lvl(pin_lvl),
    .snap_dev(snap_dev), .snap_vec(snap_vec),
    .rst_vld(rst_vld), .rst_rdy(rst_rdy), .rst_dev(rst_dev), .rst_vec(rst_vec),
    .line_out(line_out), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_lines(input logic [NP-1:0] lv);
    logic [NL-1:0] r = '0;
    for (int i = 0; i < NP; i++)
      if (lv[i]) r[((i % 4) + (i / 4)) % NL] = 1'b1;
    return r;
  endfunction

  // Drive one cycle, check ready before the edge, then lines/snapshot after it.
  task automatic step(input logic [NP-1:0] we, input logic [NP-1:0] lv,
                      input bit rv, input logic [1:0] rd, input logic [3:0] rvec,
                      input string req);
    bit fire;
    @(negedge clk);
    pin_we = we; pin_lvl = lv; rst_vld = rv; rst_dev = rd; rst_vec = rvec;
    snap_dev = snap_dev + 2'd1;
    #1;
    fire = rv && (we[rd*4 +: 4] == 4'h0);
    chk(rst_rdy == (we[rd*4 +: 4] == 4'h0), "R8", rst_rdy, we[rd*4 +: 4] == 4'h0);
    @(posedge clk);
    for (int i = 0; i < NP; i++) begin
      if (fire && (i / 4) == rd) ref_lvl[i] = rvec[i % 4];
      else if (we[i]) ref_lvl[i] = lv[i];
    end
    #1;
    chk(line_out == exp_lines(ref_lvl), req, line_out, exp_lines(ref_lvl));
    chk(snap_vec == ref_lvl[snap_dev*4 +: 4], "R6", snap_vec, ref_lvl[snap_dev*4 +: 4]);
    chk(!err_flag, "R9", err_flag, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] a, b;
    logic [NL-1:0] held;
    repeat (3) @(posedge clk);
    // Load some state, then reset: everything must clear (R1)
    rst = 1'b0;
    step('1, 16'hA5C3, 0, 0, 0, "R4");
    @(negedge clk); rst = 1'b1; pin_we = '0;
    @(posedge clk); #1;
    ref_lvl = '0;
    chk(line_out == '0, "R1", line_out, 0);
    chk(!err_flag, "R1", err_flag, 0);
    for (int d = 0; d < ND; d++) begin
      @(negedge clk); snap_dev = 2'(d); #1;
      chk(snap_vec == 4'h0, "R1", snap_vec, 0);
    end
    @(negedge clk); rst = 1'b0;

    // R3: walk each pin alone through the rotation
    for (int i = 0; i < NP; i++) begin
      step(NP'(1) << i, NP'(1) << i, 0, 0, 0, "R3");
      chk(line_out == NL'(1) << (((i % 4) + (i / 4)) % NL), "R3", line_out,
          NL'(1) << (((i % 4) + (i / 4)) % NL));
      step(NP'(1) << i, '0, 0, 0, 0, "R3");
    end

    // R5: dev0 pin0 and dev1 pin3 share line 0, dev2 pin2 also lands on line 0
    step(16'h0281, 16'h0281 & 16'h0081, 0, 0, 0, "R5");
    step(16'h0001, 16'h0000, 0, 0, 0, "R5");
    chk(line_out[0] == 1'b1, "R5", line_out[0], 1);
    // one rise and one fall on line 0 in the same cycle
    step(16'h0480, 16'h0400, 0, 0, 0, "R5");
    chk(line_out[0] == 1'b1, "R5", line_out[0], 1);
    step(16'h0400, 16'h0000, 0, 0, 0, "R5");
    chk(line_out[0] == 1'b0, "R5", line_out[0], 0);

    // R2: rewriting the stored level changes nothing
    step('1, 16'h1234, 0, 0, 0, "R4");
    held = line_out;
    step('1, 16'h1234, 0, 0, 0, "R2");
    chk(line_out == held, "R2", line_out, held);
    step(16'h00F0, 16'h0030, 0, 0, 0, "R2");
    chk(line_out == held, "R2", line_out, held);

    // R7/R8: every device and restore vector, with colliding and side writes
    for (int d = 0; d < ND; d++) begin
      for (int v = 0; v < 16; v++) begin
        a = 16'(v * 16'h2F1B + d * 16'h0D07);
        step(a & ~(16'hF << (d*4)), 16'(a * 3), 1, 2'(d), 4'(v), "R7");
        chk(ref_lvl[d*4 +: 4] == 4'(v), "R7", ref_lvl[d*4 +: 4], v);
        step(16'hF << (d*4), '0, 1, 2'(d), 4'(~v), "R8");
        chk(ref_lvl[d*4 +: 4] == 4'h0, "R8", ref_lvl[d*4 +: 4], 0);
      end
    end

    // Sweep A: full-width writes
    for (int k = 0; k < 4096; k++)
      step('1, 16'(k * 16'h9E37), 0, 0, 0, "R4");
    // Sweep B: partial strobes with occasional restores
    for (int k = 0; k < 4096; k++) begin
      a = 16'(k * 16'h03B1 + 16'h5A5A);
      b = 16'(k * 16'h07A5);
      step(a, b, (k % 5) == 0, 2'(k % 4), 4'(k / 3), "R5");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule